// File: doc/BRIEF.md
# Branch Trace Buffer with Repeat Compression

The block keeps a short history of program-flow changes taken by a processor core. Each qualified branch event stores a pair of 32-bit addresses: where the branch came from and where it went. The pairs go into a 16-entry circular store. When the store is full, a control bit chooses what happens to a new event. In one mode the oldest pair is overwritten. In the other mode the new event is refused and a one-cycle exception request goes to the core.

Tight code often repeats the same branch many times. Two optional compression modes catch these repeats. A repeat of the newest pair, or of the pair just below it, is not stored as a new entry. Instead, bit 0 of an address in the matching entry is set. Software reads the history through a small register port: a control word, an entry count, and a data word. The data word pops entries from the newest end, taking two reads per entry.

Top module: `btrace_top`

## Requirements
- R1: After reset, the control register reads zero, the count reads zero and a data read returns zero. The exception output is low.
- R2: The control register at byte offset 0x000 stores all 32 bits written and reads them back. Writes to offsets 0x004 and 0x100 change nothing. The control fields are: bit 0 power, bit 1 enable, bit 2 overflow-exception mode, bit 3 one-level compression, bit 4 two-level compression.
- R3: A read at offset 0x004 returns the number of valid entries, zero-extended and saturated at 16.
- R4: A read at offset 0x100 returns zero when the store is empty. Otherwise it reads the newest entry: the first read returns the destination address, the next returns the source address and removes that entry. An empty read does not advance the read phase.
- R5: An event is stored only when both power and enable are 1 and its loop flag is 0.
- R6: No event is stored at interrupt level 1. When overflow-exception mode is on, no event is stored at levels 0 to 3.
- R7: An event arriving at a full store with overflow-exception mode off discards the oldest entry and stores the new one.
- R8: An event arriving at a full store with overflow-exception mode on is dropped. The exception output is then high for exactly the following cycle.
- R9: With one-level compression on and at least one entry, an event equal to the newest entry's pair (bit 0 ignored on both sides) sets bit 0 of that entry's destination and adds no entry.
- R10: With two-level compression on and at least two entries, an event equal to the second-newest pair sets bit 0 of that entry's source and adds no entry. The one-level match is tried first.
- R11: A compressible event is folded even when the store is full, so it neither overwrites the oldest entry nor raises the exception.
- R12: When a data read and an event fall in the same cycle, the read returns the data held before the cycle. The pop is applied first, and the event is then handled against the remaining entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Branch event strobe |
| ev_src | input | 32 | Branch source address |
| ev_dst | input | 32 | Branch target address |
| ev_loop | input | 1 | Event comes from a hardware loop |
| ev_level | input | 4 | Current interrupt level of the core |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read pops) |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| ovf_exc | output | 1 | One-cycle overflow exception request |

## Verification
A wrong head or tail index shows up first in the count register, on the very next status read. A data read shows it too, because the read returns a stale or shifted address. A bad read-phase bit swaps source and destination on the next data read. A flawed compression comparison shows as an extra count, or as a missing bit-0 mark, when the entry is drained. A reference model compares read data and the exception output on every clock, so these errors are reported in the cycle they first become visible.

// File: rtl/btrace_pkg.sv
package btrace_pkg;
    localparam int AW   = 32;
    localparam int RA_W = 9;

    localparam logic [RA_W-1:0] OFS_CTRL = 9'h000;
    localparam logic [RA_W-1:0] OFS_STAT = 9'h004;
    localparam logic [RA_W-1:0] OFS_DATA = 9'h100;

    localparam int CB_PWR  = 0;
    localparam int CB_EN   = 1;
    localparam int CB_OVX  = 2;
    localparam int CB_CMP1 = 3;
    localparam int CB_CMP2 = 4;

    localparam int LVL_RESET = 1;
    localparam int LVL_EXCPT = 3;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
    } tb_entry_t;
endpackage

// File: rtl/btrace_gate.sv
module btrace_gate
    import btrace_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             ev_valid,
    input  logic             ev_loop,
    input  logic [LVL_W-1:0] ev_level,
    input  logic [AW-1:0]    ctrl,
    output logic             capture
);
    logic lvl_is_reset;
    logic lvl_is_high;

    always_comb begin
        lvl_is_reset = (ev_level == LVL_W'(LVL_RESET));
        lvl_is_high  = (ev_level <= LVL_W'(LVL_EXCPT));
        capture      = ev_valid & ctrl[CB_PWR] & ctrl[CB_EN] & ~ev_loop;
        if (lvl_is_reset) begin
            capture = 1'b0;
        end
        if (ctrl[CB_OVX] && lvl_is_high) begin
            capture = 1'b0;
        end
    end
endmodule

// File: rtl/btrace_ring.sv
module btrace_ring
    import btrace_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [AW-1:0]    ev_src,
    input  logic [AW-1:0]    ev_dst,
    input  logic             cmp1_en,
    input  logic             cmp2_en,
    input  logic             ovx_mode,
    input  logic             pop,
    output logic [PTR_W-1:0] count,
    output logic [AW-1:0]    rd_word,
    output logic             exc
);
    localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

    typedef struct packed {
        tb_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]      head;
        logic [PTR_W-1:0]      tail;
        logic                  mid;
        logic                  exc;
    } ring_t;

    ring_t ring_d, ring_q;

    logic [PTR_W-1:0] cnt_pre, cnt_post;
    logic [IDX_W-1:0] i_rd, i_top, i_last, i_prev;
    logic             hit1, hit2;

    function automatic logic pair_eq(tb_entry_t e, logic [AW-1:0] s, logic [AW-1:0] d);
        return (e.src[AW-1:1] == s[AW-1:1]) && (e.dst[AW-1:1] == d[AW-1:1]);
    endfunction

    always_comb begin
        ring_d     = ring_q;
        ring_d.exc = 1'b0;
        rd_word    = '0;

        cnt_pre = ring_q.head - ring_q.tail;
        i_rd    = IDX_W'(ring_q.head - PTR_W'(1));
        if (cnt_pre != '0) begin
            rd_word = ring_q.mid ? ring_q.mem[i_rd].src : ring_q.mem[i_rd].dst;
        end

        // the pop is applied first
        if (pop && (cnt_pre != '0)) begin
            if (ring_q.mid) begin
                ring_d.head = ring_q.head - PTR_W'(1);
            end
            ring_d.mid = ~ring_q.mid;
        end

        // then the event is handled against what is left
        cnt_post = ring_d.head - ring_d.tail;
        i_top    = IDX_W'(ring_d.head);
        i_last   = IDX_W'(ring_d.head - PTR_W'(1));
        i_prev   = IDX_W'(ring_d.head - PTR_W'(2));
        hit1     = cmp1_en && (cnt_post >= PTR_W'(1))
                   && pair_eq(ring_d.mem[i_last], ev_src, ev_dst);
        hit2     = cmp2_en && (cnt_post >= PTR_W'(2))
                   && pair_eq(ring_d.mem[i_prev], ev_src, ev_dst);

        if (cap) begin
            if (hit1) begin
                ring_d.mem[i_last].dst[0] = 1'b1;
            end else if (hit2) begin
                ring_d.mem[i_prev].src[0] = 1'b1;
            end else if (cnt_post == FULL && ovx_mode) begin
                ring_d.exc = 1'b1;
            end else begin
                if (cnt_post == FULL) begin
                    ring_d.tail = ring_d.tail + PTR_W'(1);
                end
                ring_d.mem[i_top] = '{src: ev_src, dst: ev_dst};
                ring_d.head       = ring_d.head + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign count = ring_q.head - ring_q.tail;
    assign exc   = ring_q.exc;
endmodule

// File: rtl/btrace_top.sv
module btrace_top
    import btrace_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int STAT_CAP = 16,
    parameter int LVL_W    = 4,
    localparam int PTR_W   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [AW-1:0]    ev_src,
    input  logic [AW-1:0]    ev_dst,
    input  logic             ev_loop,
    input  logic [LVL_W-1:0] ev_level,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [AW-1:0]    reg_wdata,
    output logic [AW-1:0]    reg_rdata,
    output logic             ovf_exc
);
    typedef struct packed {
        logic [AW-1:0] ctrl;
    } top_t;

    top_t top_d, top_q;

    logic             capture;
    logic             pop;
    logic [PTR_W-1:0] count;
    logic [AW-1:0]    rd_word;
    logic [AW-1:0]    ctrl_now;
    logic [AW-1:0]    stat_word;

    assign ctrl_now = top_q.ctrl;

    btrace_gate #(.LVL_W(LVL_W)) u_gate (
        .ev_valid (ev_valid),
        .ev_loop  (ev_loop),
        .ev_level (ev_level),
        .ctrl     (ctrl_now),
        .capture  (capture)
    );

    btrace_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (capture),
        .ev_src   (ev_src),
        .ev_dst   (ev_dst),
        .cmp1_en  (ctrl_now[CB_CMP1]),
        .cmp2_en  (ctrl_now[CB_CMP2]),
        .ovx_mode (ctrl_now[CB_OVX]),
        .pop      (pop),
        .count    (count),
        .rd_word  (rd_word),
        .exc      (ovf_exc)
    );

    always_comb begin
        top_d = top_q;
        pop   = reg_rd && (reg_addr == OFS_DATA);
        if (reg_wr && (reg_addr == OFS_CTRL)) begin
            top_d.ctrl = reg_wdata;
        end
        stat_word = (AW'(count) > AW'(STAT_CAP)) ? AW'(STAT_CAP) : AW'(count);
        case (reg_addr)
            OFS_CTRL: reg_rdata = top_q.ctrl;
            OFS_STAT: reg_rdata = stat_word;
            OFS_DATA: reg_rdata = rd_word;
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end
endmodule

// File: rtl/btrace_chk.sv
module btrace_chk
    import btrace_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    ctrl,
    input logic [PTR_W-1:0] count,
    input logic             ev_valid,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [RA_W-1:0]  reg_addr,
    input logic [AW-1:0]    reg_wdata,
    input logic [AW-1:0]    reg_rdata,
    input logic             ovf_exc
);
    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CTRL) |=> (ctrl == $past(reg_wdata)));

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PTR_W'(DEPTH));

    // R4
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_DATA && count == '0) |-> (reg_rdata == '0));

    // R5
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !(ctrl[CB_PWR] && ctrl[CB_EN]) && !(reg_rd && reg_addr == OFS_DATA))
        |=> $stable(count));

    // R8
    exc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_exc |-> ($past(ev_valid) && $past(ctrl[CB_OVX])));

    // R8
    exc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_exc |-> (count == PTR_W'(DEPTH)));
endmodule

bind btrace_top btrace_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl_now),
    .count     (count),
    .ev_valid  (ev_valid),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ovf_exc   (ovf_exc)
);

// File: tb/btrace_top_test.sv
module btrace_top_test;
    import btrace_pkg::*;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ev_valid, ev_loop, reg_wr, reg_rd;
    logic [31:0] ev_src, ev_dst, reg_wdata;
    logic [3:0]  ev_level;
    logic [8:0]  reg_addr;
    logic [31:0] reg_rdata;
    logic        ovf_exc;

    always #5 clk = ~clk;

    btrace_top uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_src(ev_src),
        .ev_dst(ev_dst), .ev_loop(ev_loop), .ev_level(ev_level),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_exc(ovf_exc)
    );

    typedef struct {
        logic [31:0] s;
        logic [31:0] d;
    } m_ent_t;

    m_ent_t      mq[$];
    logic [31:0] m_ctrl;
    bit          m_mid;
    bit          m_exc;
    int          n_chk = 0;
    int          n_bad = 0;
    string       tag = "R1";
    bit          done = 1'b0;

    task automatic chk32(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(logic [8:0] a);
        int n;
        n = mq.size();
        if (a == OFS_CTRL) return m_ctrl;
        if (a == OFS_STAT) return (n > 16) ? 32'd16 : 32'(n);
        if (a == OFS_DATA) begin
            if (n == 0) return 32'h0;
            return m_mid ? mq[n-1].s : mq[n-1].d;
        end
        return 32'h0;
    endfunction

    function automatic bit same(m_ent_t e, logic [31:0] s, logic [31:0] d);
        return (e.s[31:1] == s[31:1]) && (e.d[31:1] == d[31:1]);
    endfunction

    task automatic m_update();
        bit     g;
        int     n;
        m_ent_t t;
        g = ev_valid && m_ctrl[0] && m_ctrl[1] && !ev_loop && (ev_level != 4'd1)
            && !(m_ctrl[2] && ev_level <= 4'd3);
        if (reg_rd && reg_addr == OFS_DATA && mq.size() > 0) begin
            if (m_mid) void'(mq.pop_back());
            m_mid = !m_mid;
        end
        m_exc = 1'b0;
        if (g) begin
            n = mq.size();
            if (m_ctrl[3] && n >= 1 && same(mq[n-1], ev_src, ev_dst)) begin
                t = mq[n-1]; t.d[0] = 1'b1; mq[n-1] = t;
            end else if (m_ctrl[4] && n >= 2 && same(mq[n-2], ev_src, ev_dst)) begin
                t = mq[n-2]; t.s[0] = 1'b1; mq[n-2] = t;
            end else if (n == DEPTH && m_ctrl[2]) begin
                m_exc = 1'b1;
            end else begin
                if (n == DEPTH) void'(mq.pop_front());
                t.s = ev_src; t.d = ev_dst;
                mq.push_back(t);
            end
        end
        if (reg_wr && reg_addr == OFS_CTRL) m_ctrl = reg_wdata;
    endtask

    task automatic step(bit v, logic [31:0] s, logic [31:0] d, bit lp, logic [3:0] lv,
                        bit w, bit r, logic [8:0] a, logic [31:0] wd);
        @(negedge clk);
        ev_valid = v; ev_src = s; ev_dst = d; ev_loop = lp; ev_level = lv;
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = wd;
        #1;
        if (r) chk32("rdata", reg_rdata, m_read(a));
        chk32("ovf_exc", {31'b0, ovf_exc}, {31'b0, m_exc});
        m_update();
    endtask

    task automatic ev(logic [31:0] s, logic [31:0] d);
        step(1, s, d, 0, 4'd15, 0, 0, OFS_CTRL, 0);
    endtask
    task automatic evx(logic [31:0] s, logic [31:0] d, bit lp, logic [3:0] lv);
        step(1, s, d, lp, lv, 0, 0, OFS_CTRL, 0);
    endtask
    task automatic rd(logic [8:0] a);
        step(0, 0, 0, 0, 4'd15, 0, 1, a, 0);
    endtask
    task automatic wr(logic [8:0] a, logic [31:0] wd);
        step(0, 0, 0, 0, 4'd15, 1, 0, a, wd);
    endtask
    task automatic drain();
        for (int i = 0; i < 2 * DEPTH + 2; i++) rd(OFS_DATA);
        rd(OFS_STAT);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ev_valid = 0; ev_src = 0; ev_dst = 0; ev_loop = 0; ev_level = 15;
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        m_ctrl = 0; m_mid = 0; m_exc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        tag = "R1";
        rd(OFS_CTRL); rd(OFS_STAT); rd(OFS_DATA);

        // R2 control read/write, ignored writes
        tag = "R2";
        wr(OFS_CTRL, 32'hA5A5_5A40); rd(OFS_CTRL);
        wr(OFS_CTRL, 32'h0000_0003);
        ev(32'h100, 32'h200);
        wr(OFS_STAT, 32'hFFFF_FFFF); wr(OFS_DATA, 32'h1234_5678);
        rd(OFS_STAT); rd(OFS_CTRL); rd(9'h008);

        // R3 / R4 count and alternating pop
        tag = "R3";
        ev(32'h110, 32'h210); ev(32'h120, 32'h220);
        rd(OFS_STAT);
        tag = "R4";
        drain();

        // R5 power, enable, loop gating
        tag = "R5";
        wr(OFS_CTRL, 32'h1); ev(32'h300, 32'h400); rd(OFS_STAT);
        wr(OFS_CTRL, 32'h2); ev(32'h300, 32'h400); rd(OFS_STAT);
        wr(OFS_CTRL, 32'h3); evx(32'h300, 32'h400, 1, 4'd15); rd(OFS_STAT);
        evx(32'h304, 32'h404, 0, 4'd15); rd(OFS_STAT);

        // R6 level gating
        tag = "R6";
        evx(32'h500, 32'h600, 0, 4'd1); evx(32'h504, 32'h604, 0, 4'd0); rd(OFS_STAT);
        wr(OFS_CTRL, 32'h7);
        evx(32'h508, 32'h608, 0, 4'd2); evx(32'h50C, 32'h60C, 0, 4'd3);
        evx(32'h510, 32'h610, 0, 4'd4); rd(OFS_STAT);
        drain();

        // R7 overwrite oldest
        tag = "R7";
        wr(OFS_CTRL, 32'h3);
        for (int i = 0; i < 20; i++) ev(32'h1000 + 32'(i * 8), 32'h2000 + 32'(i * 8));
        rd(OFS_STAT);
        drain();

        // R8 overflow exception
        tag = "R8";
        wr(OFS_CTRL, 32'h7);
        for (int i = 0; i < 17; i++) ev(32'h3000 + 32'(i * 8), 32'h4000 + 32'(i * 8));
        ev(32'h3F00, 32'h4F00);
        step(0, 0, 0, 0, 4'd15, 0, 1, OFS_STAT, 0);
        rd(OFS_STAT);
        drain();

        // R9 / R10 compression
        tag = "R9";
        wr(OFS_CTRL, 32'h1B);
        ev(32'h700, 32'h800); ev(32'h700, 32'h800); rd(OFS_STAT);
        ev(32'h710, 32'h810); ev(32'h711, 32'h811); rd(OFS_STAT);
        tag = "R10";
        ev(32'h700, 32'h800); rd(OFS_STAT);
        ev(32'h720, 32'h820); ev(32'h720, 32'h820); rd(OFS_STAT);
        drain();
        wr(OFS_CTRL, 32'h13);
        ev(32'h900, 32'hA00); ev(32'h900, 32'hA00); rd(OFS_STAT);
        drain();

        // R11 folding at a full store
        tag = "R11";
        wr(OFS_CTRL, 32'h1F);
        for (int i = 0; i < 16; i++) ev(32'h5000 + 32'(i * 8), 32'h6000 + 32'(i * 8));
        ev(32'h5000 + 32'(15 * 8), 32'h6000 + 32'(15 * 8));
        ev(32'h5000 + 32'(14 * 8), 32'h6000 + 32'(14 * 8));
        rd(OFS_STAT);
        rd(OFS_STAT);
        drain();

        // R12 read and event in the same cycle
        tag = "R12";
        wr(OFS_CTRL, 32'h3);
        ev(32'hB00, 32'hC00); ev(32'hB10, 32'hC10);
        rd(OFS_DATA);
        step(1, 32'hB20, 32'hC20, 0, 4'd15, 0, 1, OFS_DATA, 0);
        rd(OFS_STAT);
        step(1, 32'hB30, 32'hC30, 0, 4'd15, 0, 1, OFS_DATA, 0);
        drain();
        rd(OFS_STAT);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule